// File: doc/BRIEF.md
# Graded Sleep and Wake-up Power Sequencer

This block decides which clocks and analog sources stay alive while the processor sleeps. A one-cycle sleep command carries a three-bit depth index. The block then moves from the running state into one of six graded sleep depths. Each depth removes a larger set of resources, in this order: the processor clock, the high-speed bus clock, the peripheral bus clocks, the main crystal oscillators and PLLs, the bandgap reference and brown-out detectors, and finally the RC and 32 kHz oscillators.

While asleep, the block watches interrupt lines grouped by source class: miscellaneous, peripheral bus, RTC, synchronous external, asynchronous external, and the external reset pin. Only the classes that the selected depth allows are honoured, because a source whose clock is stopped cannot raise a wake-up.

On wake-up the block brings every analog source back first. It waits for their ready inputs, then restores the bus clocks as the software clock mask requests, and only after that restarts the processor clock. During sleep the depth overrides the mask: a stopped domain stays off whatever the mask says.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, and whenever running (`pwr_mode` = 7), `cpu_clk_en` is 1, `bus_clk_en` equals `bus_mask`, and every oscillator, PLL, RC, bandgap and brown-out enable is 1. `osc32_en` equals `osc32_cfg`.
- R2: Depth index 0..5 selects Idle, Frozen, Standby, Stop, DeepStop and Static. Indices 6 and 7 behave as Static, and `pwr_mode` then reports 5. `pwr_mode` never shows 6.
- R3: Idle (0) stops only the processor clock. Any interrupt class except the reset pin wakes it.
- R4: Frozen (1) also stops the high-speed bus domain (`bus_clk_en[0]`). The peripheral bus domains (`bus_clk_en[N_PB_DOM:1]`) keep following `bus_mask`. Only a peripheral-bus interrupt wakes it.
- R5: Standby (2) stops every bus domain whatever `bus_mask` holds, and keeps the oscillators and PLLs on. An RTC interrupt or an external interrupt (sync or async) wakes it.
- R6: Stop (3) additionally clears `osc_en` and `pll_en`. It keeps `rc_en`, `bg_en` and `bod_en` at 1, and holds `osc32_en` at `osc32_cfg`. RTC, external interrupts or the reset pin wake it.
- R7: DeepStop (4) additionally clears `bg_en` and `bod_en`, and has the same wake-up set as Stop.
- R8: Static (5) additionally clears `rc_en` and `osc32_en`. Only an asynchronous external interrupt or the reset pin wakes it.
- R9: A wake-up source that is not allowed in the current depth leaves every output unchanged.
- R10: After an allowed wake-up, all analog enables return to their running values while every clock stays off. The block waits until every `osc_rdy`, every `pll_rdy`, `rc_rdy`, and `osc32_rdy` (when `osc32_cfg` is 1) are high. It then spends one cycle with the bus clocks per `bus_mask` and the processor clock off, then runs.
- R11: A sleep command that arrives while not running is ignored: `pwr_mode` keeps its value until the block returns to 7.
- R12: A sleep command sampled at a rising edge while running changes the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle sleep command |
| sleep_mode | input | 3 | Sleep depth index |
| bus_mask | input | N_PB_DOM+1 | Software clock mask; bit 0 high-speed bus, upper bits peripheral buses |
| osc32_cfg | input | 1 | 32 kHz oscillator enabled by software |
| irq_misc | input | N_MISC | Other interrupt lines (count only for Idle) |
| irq_pb | input | N_PBI | Peripheral-bus interrupt lines |
| irq_rtc | input | 1 | RTC interrupt |
| irq_ext_sync | input | N_EXT | External interrupts in synchronous mode |
| irq_ext_async | input | N_EXT | External interrupts in asynchronous mode |
| ext_rst_wake | input | 1 | External reset pin asserted |
| osc_rdy | input | N_OSC | Main oscillators stable |
| pll_rdy | input | N_PLL | PLLs locked |
| rc_rdy | input | 1 | RC oscillator stable |
| osc32_rdy | input | 1 | 32 kHz oscillator stable |
| cpu_clk_en | output | 1 | Processor clock enable |
| bus_clk_en | output | N_PB_DOM+1 | Bus domain clock enables |
| osc_en | output | N_OSC | Main oscillator enables |
| pll_en | output | N_PLL | PLL enables |
| rc_en | output | 1 | RC oscillator enable |
| osc32_en | output | 1 | 32 kHz oscillator enable |
| bg_en | output | 1 | Bandgap reference enable |
| bod_en | output | N_BOD | Brown-out detector enables |
| pwr_mode | output | 3 | Current depth 0..5, or 7 when running |

## Verification
Every depth index, including the two aliases of Static, is entered and then offered first a wake-up class it must refuse and then one it must accept. This separates a depth that decodes the right stop set but the wrong wake set from one that gets both right.

The bus mask is varied between runs, and the 32 kHz setting is toggled. This shows whether the depth or the mask wins for each domain.

One wake-up is run with the ready inputs held low for many cycles. This tells a sequencer that truly waits for ready apart from one that restores clocks early.

A sleep command issued during sleep shows whether the stored depth can be overwritten.

// File: rtl/pwr_sleep_pkg.sv
`timescale 1ns/1ps
package pwr_sleep_pkg;

    localparam logic [2:0] PWR_MODE_RUN = 3'd7;

    typedef enum logic [2:0] {
        SM_IDLE     = 3'd0,
        SM_FROZEN   = 3'd1,
        SM_STANDBY  = 3'd2,
        SM_STOP     = 3'd3,
        SM_DEEPSTOP = 3'd4,
        SM_STATIC   = 3'd5
    } sleep_mode_e;

    typedef enum logic [1:0] {
        PS_RUN,
        PS_SLEEP,
        PS_WAKE_ANALOG,
        PS_WAKE_BUS
    } pwr_state_e;

    // Resources removed by a depth
    typedef struct packed {
        logic cut_hsb;
        logic cut_pb;
        logic cut_main_osc;
        logic cut_refs;
        logic cut_lowfreq;
    } cut_set_t;

    // Interrupt classes honoured by a depth
    typedef struct packed {
        logic any;
        logic pb;
        logic rtc;
        logic ext_sync;
        logic ext_async;
        logic pin;
    } wake_set_t;

    typedef struct packed {
        cut_set_t  cut;
        wake_set_t wake;
    } mode_cfg_t;

    function automatic sleep_mode_e clamp_mode(input logic [2:0] idx);
        sleep_mode_e m;
        if (idx > 3'd5) m = SM_STATIC;
        else            m = sleep_mode_e'(idx);
        return m;
    endfunction

    function automatic mode_cfg_t mode_cfg(input sleep_mode_e m);
        mode_cfg_t c;
        c = '0;
        c.cut.cut_hsb      = (m != SM_IDLE);
        c.cut.cut_pb       = (m inside {SM_STANDBY, SM_STOP, SM_DEEPSTOP, SM_STATIC});
        c.cut.cut_main_osc = (m inside {SM_STOP, SM_DEEPSTOP, SM_STATIC});
        c.cut.cut_refs     = (m inside {SM_DEEPSTOP, SM_STATIC});
        c.cut.cut_lowfreq  = (m == SM_STATIC);
        unique case (m)
            SM_IDLE:     c.wake.any = 1'b1;
            SM_FROZEN:   c.wake.pb  = 1'b1;
            SM_STANDBY: begin
                c.wake.rtc       = 1'b1;
                c.wake.ext_sync  = 1'b1;
                c.wake.ext_async = 1'b1;
            end
            SM_STOP, SM_DEEPSTOP: begin
                c.wake.rtc       = 1'b1;
                c.wake.ext_sync  = 1'b1;
                c.wake.ext_async = 1'b1;
                c.wake.pin       = 1'b1;
            end
            default: begin
                c.wake.ext_async = 1'b1;
                c.wake.pin       = 1'b1;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwr_mode_table.sv
`timescale 1ns/1ps
module pwr_mode_table
    import pwr_sleep_pkg::*;
(
    input  sleep_mode_e mode,
    output mode_cfg_t   cfg
);
    always_comb begin
        cfg = mode_cfg(mode);
    end
endmodule

// File: rtl/pwr_wake_qual.sv
`timescale 1ns/1ps
module pwr_wake_qual
    import pwr_sleep_pkg::*;
#(
    parameter int N_MISC = 4,
    parameter int N_PBI  = 8,
    parameter int N_EXT  = 4
)(
    input  wake_set_t           allow,
    input  logic [N_MISC-1:0]   irq_misc,
    input  logic [N_PBI-1:0]    irq_pb,
    input  logic                irq_rtc,
    input  logic [N_EXT-1:0]    irq_ext_sync,
    input  logic [N_EXT-1:0]    irq_ext_async,
    input  logic                ext_rst_wake,
    output logic                wake_hit
);
    wake_set_t seen;

    always_comb begin
        seen.pb        = |irq_pb;
        seen.rtc       = irq_rtc;
        seen.ext_sync  = |irq_ext_sync;
        seen.ext_async = |irq_ext_async;
        seen.pin       = ext_rst_wake;
        seen.any       = (|irq_misc) | seen.pb | seen.rtc | seen.ext_sync | seen.ext_async;
    end

    assign wake_hit = |(seen & allow);
endmodule

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
module pwr_seq_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int N_OSC = 2,
    parameter int N_PLL = 2
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req,
    input  logic [2:0]       sleep_mode,
    input  logic             wake_hit,
    input  logic [N_OSC-1:0] osc_rdy,
    input  logic [N_PLL-1:0] pll_rdy,
    input  logic             rc_rdy,
    input  logic             osc32_rdy,
    input  logic             osc32_cfg,
    output pwr_state_e       state,
    output sleep_mode_e      mode_q,
    output logic [2:0]       pwr_mode
);
    pwr_state_e  state_nx;
    sleep_mode_e mode_nx;
    logic        analog_ready;

    assign analog_ready = (&osc_rdy) & (&pll_rdy) & rc_rdy & (osc32_rdy | ~osc32_cfg);

    always_comb begin
        state_nx = state;
        mode_nx  = mode_q;
        unique case (state)
            PS_RUN: if (sleep_req) begin
                state_nx = PS_SLEEP;
                mode_nx  = clamp_mode(sleep_mode);
            end
            PS_SLEEP:       if (wake_hit)     state_nx = PS_WAKE_ANALOG;
            PS_WAKE_ANALOG: if (analog_ready) state_nx = PS_WAKE_BUS;
            default:                          state_nx = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PS_RUN;
            mode_q <= SM_IDLE;
        end else begin
            state  <= state_nx;
            mode_q <= mode_nx;
        end
    end

    assign pwr_mode = (state == PS_RUN) ? PWR_MODE_RUN : mode_q;
endmodule

// File: rtl/pwr_enable_gen.sv
`timescale 1ns/1ps
module pwr_enable_gen
    import pwr_sleep_pkg::*;
#(
    parameter int N_BUS = 3,
    parameter int N_OSC = 2,
    parameter int N_PLL = 2,
    parameter int N_BOD = 2
)(
    input  pwr_state_e       state,
    input  cut_set_t         cut,
    input  logic [N_BUS-1:0] bus_mask,
    input  logic             osc32_cfg,
    output logic             cpu_clk_en,
    output logic [N_BUS-1:0] bus_clk_en,
    output logic [N_OSC-1:0] osc_en,
    output logic [N_PLL-1:0] pll_en,
    output logic             rc_en,
    output logic             osc32_en,
    output logic             bg_en,
    output logic [N_BOD-1:0] bod_en
);
    logic clocks_held;
    logic analog_held;

    // Clocks stay gated through the analog restart; analog cuts apply only while asleep
    assign clocks_held = (state == PS_SLEEP) || (state == PS_WAKE_ANALOG);
    assign analog_held = (state == PS_SLEEP);
    assign cpu_clk_en  = (state == PS_RUN);

    for (genvar d = 0; d < N_BUS; d++) begin : g_bus
        if (d == 0) begin : g_hsb
            assign bus_clk_en[d] = bus_mask[d] & ~(clocks_held & cut.cut_hsb);
        end else begin : g_pb
            assign bus_clk_en[d] = bus_mask[d] & ~(clocks_held & cut.cut_pb);
        end
    end

    assign osc_en   = {N_OSC{~(analog_held & cut.cut_main_osc)}};
    assign pll_en   = {N_PLL{~(analog_held & cut.cut_main_osc)}};
    assign bg_en    = ~(analog_held & cut.cut_refs);
    assign bod_en   = {N_BOD{~(analog_held & cut.cut_refs)}};
    assign rc_en    = ~(analog_held & cut.cut_lowfreq);
    assign osc32_en = osc32_cfg & ~(analog_held & cut.cut_lowfreq);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int N_PB_DOM = 2,
    parameter int N_MISC   = 4,
    parameter int N_PBI    = 8,
    parameter int N_EXT    = 4,
    parameter int N_OSC    = 2,
    parameter int N_PLL    = 2,
    parameter int N_BOD    = 2,
    localparam int N_BUS   = N_PB_DOM + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic [2:0]        sleep_mode,
    input  logic [N_BUS-1:0]  bus_mask,
    input  logic              osc32_cfg,
    input  logic [N_MISC-1:0] irq_misc,
    input  logic [N_PBI-1:0]  irq_pb,
    input  logic              irq_rtc,
    input  logic [N_EXT-1:0]  irq_ext_sync,
    input  logic [N_EXT-1:0]  irq_ext_async,
    input  logic              ext_rst_wake,
    input  logic [N_OSC-1:0]  osc_rdy,
    input  logic [N_PLL-1:0]  pll_rdy,
    input  logic              rc_rdy,
    input  logic              osc32_rdy,
    output logic              cpu_clk_en,
    output logic [N_BUS-1:0]  bus_clk_en,
    output logic [N_OSC-1:0]  osc_en,
    output logic [N_PLL-1:0]  pll_en,
    output logic              rc_en,
    output logic              osc32_en,
    output logic              bg_en,
    output logic [N_BOD-1:0]  bod_en,
    output logic [2:0]        pwr_mode
);
    pwr_state_e  state;
    sleep_mode_e mode_q;
    mode_cfg_t   cfg;
    logic        wake_hit;

    pwr_mode_table u_table (
        .mode (mode_q),
        .cfg  (cfg)
    );

    pwr_wake_qual #(.N_MISC(N_MISC), .N_PBI(N_PBI), .N_EXT(N_EXT)) u_wake (
        .allow         (cfg.wake),
        .irq_misc      (irq_misc),
        .irq_pb        (irq_pb),
        .irq_rtc       (irq_rtc),
        .irq_ext_sync  (irq_ext_sync),
        .irq_ext_async (irq_ext_async),
        .ext_rst_wake  (ext_rst_wake),
        .wake_hit      (wake_hit)
    );

    pwr_seq_fsm #(.N_OSC(N_OSC), .N_PLL(N_PLL)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .sleep_mode (sleep_mode),
        .wake_hit   (wake_hit),
        .osc_rdy    (osc_rdy),
        .pll_rdy    (pll_rdy),
        .rc_rdy     (rc_rdy),
        .osc32_rdy  (osc32_rdy),
        .osc32_cfg  (osc32_cfg),
        .state      (state),
        .mode_q     (mode_q),
        .pwr_mode   (pwr_mode)
    );

    pwr_enable_gen #(.N_BUS(N_BUS), .N_OSC(N_OSC), .N_PLL(N_PLL), .N_BOD(N_BOD)) u_en (
        .state      (state),
        .cut        (cfg.cut),
        .bus_mask   (bus_mask),
        .osc32_cfg  (osc32_cfg),
        .cpu_clk_en (cpu_clk_en),
        .bus_clk_en (bus_clk_en),
        .osc_en     (osc_en),
        .pll_en     (pll_en),
        .rc_en      (rc_en),
        .osc32_en   (osc32_en),
        .bg_en      (bg_en),
        .bod_en     (bod_en)
    );
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_chk #(
    parameter int N_BUS = 3,
    parameter int N_OSC = 2,
    parameter int N_PLL = 2
)(
    input logic             clk,
    input logic             rst,
    input logic             sleep_req,
    input logic             cpu_clk_en,
    input logic [N_BUS-1:0] bus_clk_en,
    input logic [N_OSC-1:0] osc_en,
    input logic [N_PLL-1:0] pll_en,
    input logic             rc_en,
    input logic             bg_en,
    input logic [2:0]       pwr_mode
);
    AST_RUN_ANALOG_ON: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> ((&osc_en) && (&pll_en) && rc_en && bg_en)); // R1

    AST_NO_CODE_SIX: assert property (@(posedge clk) disable iff (rst)
        pwr_mode != 3'd6); // R2

    AST_BG_ONLY_DEEP: assert property (@(posedge clk) disable iff (rst)
        !bg_en |-> (pwr_mode == 3'd4 || pwr_mode == 3'd5)); // R7

    AST_RC_ONLY_STATIC: assert property (@(posedge clk) disable iff (rst)
        !rc_en |-> (pwr_mode == 3'd5)); // R8

    AST_CPU_HELD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode != 3'd7) |-> !cpu_clk_en); // R10

    AST_CLOCKS_AFTER_OSC: assert property (@(posedge clk) disable iff (rst)
        (!cpu_clk_en && !(&osc_en)) |-> (bus_clk_en == '0)); // R10

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode != 3'd7) |=> (pwr_mode == $past(pwr_mode) || pwr_mode == 3'd7)); // R11

    AST_ENTRY_NEXT: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 3'd7 && sleep_req) |=> (pwr_mode != 3'd7)); // R12
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.N_BUS(N_BUS), .N_OSC(N_OSC), .N_PLL(N_PLL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .cpu_clk_en (cpu_clk_en),
    .bus_clk_en (bus_clk_en),
    .osc_en     (osc_en),
    .pll_en     (pll_en),
    .rc_en      (rc_en),
    .bg_en      (bg_en),
    .pwr_mode   (pwr_mode)
);

// File: tb/pwr_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_bench;
    localparam int N_PB_DOM = 2;
    localparam int N_BUS    = N_PB_DOM + 1;
    localparam int N_MISC   = 4;
    localparam int N_PBI    = 8;
    localparam int N_EXT    = 4;
    localparam int N_OSC    = 2;
    localparam int N_PLL    = 2;
    localparam int N_BOD    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              sleep_req = 1'b0;
    logic [2:0]        sleep_mode = 3'd0;
    logic [N_BUS-1:0]  bus_mask = '1;
    logic              osc32_cfg = 1'b1;
    logic [N_MISC-1:0] irq_misc = '0;
    logic [N_PBI-1:0]  irq_pb = '0;
    logic              irq_rtc = 1'b0;
    logic [N_EXT-1:0]  irq_ext_sync = '0;
    logic [N_EXT-1:0]  irq_ext_async = '0;
    logic              ext_rst_wake = 1'b0;
    logic [N_OSC-1:0]  osc_rdy = '0;
    logic [N_PLL-1:0]  pll_rdy = '0;
    logic              rc_rdy = 1'b0;
    logic              osc32_rdy = 1'b0;

    logic              cpu_clk_en;
    logic [N_BUS-1:0]  bus_clk_en;
    logic [N_OSC-1:0]  osc_en;
    logic [N_PLL-1:0]  pll_en;
    logic              rc_en;
    logic              osc32_en;
    logic              bg_en;
    logic [N_BOD-1:0]  bod_en;
    logic [2:0]        pwr_mode;

    pwr_sleep_ctrl #(.N_PB_DOM(N_PB_DOM), .N_MISC(N_MISC), .N_PBI(N_PBI), .N_EXT(N_EXT),
                     .N_OSC(N_OSC), .N_PLL(N_PLL), .N_BOD(N_BOD)) u_pwr_sleep_ctrl (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .bus_mask(bus_mask), .osc32_cfg(osc32_cfg), .irq_misc(irq_misc), .irq_pb(irq_pb),
        .irq_rtc(irq_rtc), .irq_ext_sync(irq_ext_sync), .irq_ext_async(irq_ext_async),
        .ext_rst_wake(ext_rst_wake), .osc_rdy(osc_rdy), .pll_rdy(pll_rdy), .rc_rdy(rc_rdy),
        .osc32_rdy(osc32_rdy), .cpu_clk_en(cpu_clk_en), .bus_clk_en(bus_clk_en),
        .osc_en(osc_en), .pll_en(pll_en), .rc_en(rc_en), .osc32_en(osc32_en),
        .bg_en(bg_en), .bod_en(bod_en), .pwr_mode(pwr_mode)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    bit    rdy_hold = 1'b0;
    int    an_cnt = 0;
    string cur_req = "R1";

    // Behavioural reference: 0 run, 1 asleep, 2 analog restart, 3 bus restart
    int m_st = 0;
    int m_md = 0;

    function automatic bit allowed_wake(input int md);
        bit pb, rtc, es, ea, pin, any;
        pb  = |irq_pb;
        rtc = irq_rtc;
        es  = |irq_ext_sync;
        ea  = |irq_ext_async;
        pin = ext_rst_wake;
        any = (|irq_misc) || pb || rtc || es || ea;
        case (md)
            0:       return any;
            1:       return pb;
            2:       return rtc || es || ea;
            3, 4:    return rtc || es || ea || pin;
            default: return ea || pin;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0;
            m_md <= 0;
        end else begin
            case (m_st)
                0: if (sleep_req) begin
                    m_st <= 1;
                    m_md <= (sleep_mode > 3'd5) ? 5 : int'(sleep_mode);
                end
                1: if (allowed_wake(m_md)) m_st <= 2;
                2: if ((&osc_rdy) && (&pll_rdy) && rc_rdy && (osc32_rdy || !osc32_cfg)) m_st <= 3;
                default: m_st <= 0;
            endcase
        end
    end

    function automatic logic [15:0] expected_vec();
        logic             e_cpu, gate, main_off, ref_off, lf_off;
        logic [N_BUS-1:0] e_bus;
        logic [2:0]       e_mode;
        e_cpu    = (m_st == 0);
        gate     = (m_st == 1) || (m_st == 2);
        main_off = (m_st == 1) && (m_md >= 3);
        ref_off  = (m_st == 1) && (m_md >= 4);
        lf_off   = (m_st == 1) && (m_md == 5);
        for (int i = 0; i < N_BUS; i++) begin
            if (i == 0) e_bus[i] = bus_mask[i] && !(gate && m_md != 0);
            else        e_bus[i] = bus_mask[i] && !(gate && m_md >= 2);
        end
        e_mode = (m_st == 0) ? 3'd7 : 3'(m_md);
        return {e_cpu, e_bus, {N_OSC{!main_off}}, {N_PLL{!main_off}}, !lf_off,
                osc32_cfg && !lf_off, !ref_off, {N_BOD{!ref_off}}, e_mode};
    endfunction

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [15:0] act, exp_v;
            act   = {cpu_clk_en, bus_clk_en, osc_en, pll_en, rc_en, osc32_en, bg_en, bod_en, pwr_mode};
            exp_v = expected_vec();
            n_checks++;
            if (act !== exp_v) begin
                n_errors++;
                $display("FAIL %s: outputs %b expected %b (cycle %0d)", cur_req, act, exp_v, cycles);
            end
        end
    end

    // Analog start-up model: ready three cycles after all enables are on
    always @(negedge clk) begin
        #1;
        if ((&osc_en) && (&pll_en) && rc_en) an_cnt = (an_cnt < 10) ? an_cnt + 1 : an_cnt;
        else an_cnt = 0;
        osc_rdy   = {N_OSC{(an_cnt >= 3) && !rdy_hold}};
        pll_rdy   = {N_PLL{(an_cnt >= 3) && !rdy_hold}};
        rc_rdy    = (an_cnt >= 3) && !rdy_hold;
        osc32_rdy = osc32_en;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp_v, input string tag);
        n_checks++;
        if (act !== exp_v) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // Source ids: 0 misc, 1 peripheral bus, 2 RTC, 3 ext sync, 4 ext async, 5 reset pin
    task automatic set_src(input int id, input logic v);
        case (id)
            0: irq_misc[1]      = v;
            1: irq_pb[5]        = v;
            2: irq_rtc          = v;
            3: irq_ext_sync[2]  = v;
            4: irq_ext_async[3] = v;
            default: ext_rst_wake = v;
        endcase
    endtask

    task automatic run_mode(input logic [2:0] idx, input string tag, input int wrong,
                            input int right, input int hold);
        int exp_mode;
        exp_mode   = (idx > 3'd5) ? 5 : int'(idx);
        cur_req    = tag;
        sleep_mode = idx;
        sleep_req  = 1'b1;
        tick(1);
        sleep_req  = 1'b0;
        check_eq(32'(pwr_mode), 32'(exp_mode), "R12");
        tick(3);
        check_eq(32'(pwr_mode), 32'(exp_mode), tag);
        cur_req = "R9";
        set_src(wrong, 1'b1);
        tick(3);
        set_src(wrong, 1'b0);
        tick(2);
        check_eq(32'(pwr_mode), 32'(exp_mode), "R9");
        cur_req  = tag;
        rdy_hold = (hold > 0);
        set_src(right, 1'b1);
        tick(2);
        set_src(right, 1'b0);
        if (hold > 0) begin
            tick(hold);
            check_eq(32'(cpu_clk_en), 32'd0, "R10");
            rdy_hold = 1'b0;
        end
        for (int k = 0; k < 60 && !cpu_clk_en; k++) tick(1);
        check_eq(32'(pwr_mode), 32'd7, tag);
        tick(2);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        check_eq(32'(pwr_mode), 32'd7, "R1");
        check_eq(32'(bus_clk_en), 32'(bus_mask), "R1");
        tick(2);

        run_mode(3'd0, "R3", 5, 0, 0);
        bus_mask = 3'b110;
        run_mode(3'd1, "R4", 2, 1, 0);
        bus_mask = 3'b111;
        run_mode(3'd2, "R5", 1, 3, 0);
        run_mode(3'd3, "R6", 0, 5, 0);
        osc32_cfg = 1'b0;
        run_mode(3'd3, "R6", 1, 2, 0);
        osc32_cfg = 1'b1;
        run_mode(3'd4, "R7", 1, 2, 0);
        run_mode(3'd5, "R8", 2, 4, 0);
        run_mode(3'd5, "R8", 3, 5, 0);
        run_mode(3'd6, "R2", 0, 4, 0);
        run_mode(3'd7, "R2", 3, 5, 0);
        run_mode(3'd3, "R10", 0, 2, 12);

        // Sleep command while asleep must not replace the stored depth
        cur_req    = "R11";
        sleep_mode = 3'd1;
        sleep_req  = 1'b1;
        tick(1);
        sleep_req  = 1'b0;
        tick(2);
        sleep_mode = 3'd5;
        sleep_req  = 1'b1;
        tick(2);
        sleep_req  = 1'b0;
        check_eq(32'(pwr_mode), 32'd1, "R11");
        set_src(1, 1'b1);
        tick(2);
        set_src(1, 1'b0);
        for (int k = 0; k < 60 && !cpu_clk_en; k++) tick(1);
        check_eq(32'(pwr_mode), 32'd7, "R11");
        tick(3);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule